// File: doc/BRIEF.md
# Read Calibration Command Sequencer

This block sits on the controller side of a DDR3 interface and drives the command, bank and address bus while the read-capture path is being trained. A single start pulse launches a fixed protocol. The block first closes every bank. It then turns on the predefined-pattern register through mode register 3. Next it issues calibration reads, each of which returns a fixed alternating data burst. Finally it turns the pattern register off again. Between commands it waits out the precharge, mode-register and pattern-register timing, and it fills every other cycle with no-operation.

An external training block watches the returned bursts and raises a capture-optimized input once the capture point is tuned. That input ends the read loop. The five timing values are clock counts that the block latches at start. The block reports that it owns the bus on a busy output. It raises a one-cycle done pulse when the bus may be handed back to normal traffic.

Command codes on `cmd_o`: 0 = no-operation, 1 = precharge all banks, 2 = mode register set, 3 = read, 4 = write.

Top module: `rdcal_seq`

## Requirements
- R1: While reset is high and after it, until the first start, the outputs show command 0, bank 0, address 0, busy low and done low.
- R2: A start sampled while idle puts a precharge-all on the bus in the next cycle, with bank 0 and address 0x0400 (bit 10 set, all others clear).
- R3: The entry mode-register write appears max(t_rp,1) cycles after the precharge. It targets bank 3 with address 0x0004 (bit 2 set, bits 1:0 and all others clear).
- R4: The first calibration read appears max(t_mrd,t_mod,1) cycles after the entry mode-register write.
- R5: Every calibration read carries bank 0 and address 0x1000 (bit 12 set; bits 2:0 and all other bits clear).
- R6: Consecutive calibration reads are max(t_gap,4) cycles apart.
- R7: No read is issued at or after the clock edge where cap_ok is first sampled high in the read loop. Even if a read is due at that very edge, it is dropped.
- R8: The exit mode-register write (bank 3, address 0) appears at the later of two points: the edge where cap_ok is first sampled, and max(t_mprr,1) cycles after the last read.
- R9: busy_o is high from the cycle after start until done. done_o is a single-cycle pulse that appears max(t_mrd,t_mod,1) cycles after the exit mode-register write, in the same cycle busy_o falls.
- R10: Every cycle between the commands above shows command 0 with bank 0 and address 0, and command 4 (write) never appears.
- R11: A start pulse or a change on any timing input while busy has no effect on the command sequence in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a calibration sequence when idle |
| cap_ok | input | 1 | Capture optimized; ends the read loop |
| t_rp | input | 8 | Precharge wait in cycles |
| t_mrd | input | 8 | Mode-register command spacing in cycles |
| t_mod | input | 8 | Mode-register update delay in cycles |
| t_mprr | input | 8 | Last-read to exit wait in cycles |
| t_gap | input | 8 | Read-to-read spacing in cycles (floor 4) |
| cmd_o | output | 3 | Command code |
| ba_o | output | 3 | Bank address |
| addr_o | output | 14 | Row/column address |
| busy_o | output | 1 | Sequence owns the bus |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every command shows on the bus in the cycle after the clock edge that decides it. The precharge comes one cycle after start is sampled. Each later command comes its clamped wait after the previous one. The exit write comes at the later of the cap_ok edge and the pattern-register wait from the last read. Done comes one mode wait after that. The bench turns each run's inputs into an expected per-edge schedule with plain integers and compares the whole bus, busy and done half a period after every edge. A misplaced command therefore fails in the exact cycle where it goes wrong. The runs cover zero timing values, a gap below the floor, cap_ok landing on a due read, a long pattern-register wait, and a stray start with changed timing mid-run.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int TIME_W      = 8;
    localparam int ADDR_W      = 14;
    localparam int BA_W        = 3;
    localparam int CMD_W       = 3;
    localparam int MR3_SEL     = 3;
    localparam int MPR_EN_BIT  = 2;
    localparam int BL8_BIT     = 12;
    localparam int ALLBANK_BIT = 10;
    localparam int GAP_FLOOR   = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP    = 3'd0,
        CMD_PREALL = 3'd1,
        CMD_MRS    = 3'd2,
        CMD_READ   = 3'd3,
        CMD_WRITE  = 3'd4
    } cal_cmd_e;

    typedef enum logic [2:0] {
        ISS_NONE,
        ISS_PRE,
        ISS_MPR_ON,
        ISS_READ,
        ISS_MPR_OFF
    } iss_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_WAIT,
        ST_ON_WAIT,
        ST_RD_WAIT,
        ST_OFF_WAIT
    } st_e;

    typedef struct packed {
        cal_cmd_e            cmd;
        logic [BA_W-1:0]     ba;
        logic [ADDR_W-1:0]   addr;
    } bus_t;

    // Latched wait targets, each already reduced to "elapsed count minus one".
    typedef struct packed {
        logic [TIME_W-1:0] rp;
        logic [TIME_W-1:0] mode;
        logic [TIME_W-1:0] mprr;
        logic [TIME_W-1:0] gap;
    } times_t;

    function automatic logic [TIME_W-1:0] tmax(input logic [TIME_W-1:0] a,
                                               input logic [TIME_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    // Clamp a cycle count to a floor (>= 1) and convert it to a compare target.
    function automatic logic [TIME_W-1:0] wait_tgt(input logic [TIME_W-1:0] v,
                                                   input logic [TIME_W-1:0] floor_v);
        return tmax(v, floor_v) - TIME_W'(1);
    endfunction
endpackage

// File: rtl/cal_wait.sv
module cal_wait
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [TIME_W-1:0] target,
    output logic              expired
);
    logic [TIME_W-1:0] el_q;

    // Saturating count of edges since the last issued command.
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            el_q <= '0;
        end else if (el_q != '1) begin
            el_q <= el_q + TIME_W'(1);
        end
    end

    assign expired = (el_q >= target);

    // R6: the elapsed counter saturates instead of wrapping, so long waits still expire.
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (el_q == '1 && !restart) |=> (el_q == '1));
endmodule

// File: rtl/cal_enc.sv
module cal_enc
    import cal_pkg::*;
(
    input  iss_e kind,
    output bus_t bus
);
    always_comb begin
        bus = '{cmd: CMD_NOP, ba: '0, addr: '0};
        unique case (kind)
            ISS_PRE: begin
                bus.cmd               = CMD_PREALL;
                bus.addr[ALLBANK_BIT] = 1'b1;
            end
            ISS_MPR_ON: begin
                bus.cmd              = CMD_MRS;
                bus.ba               = BA_W'(MR3_SEL);
                bus.addr[MPR_EN_BIT] = 1'b1;
            end
            ISS_READ: begin
                bus.cmd           = CMD_READ;
                bus.addr[BL8_BIT] = 1'b1;
            end
            ISS_MPR_OFF: begin
                bus.cmd = CMD_MRS;
                bus.ba  = BA_W'(MR3_SEL);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cal_fsm.sv
module cal_fsm
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cap_ok,
    input  logic [TIME_W-1:0] t_rp,
    input  logic [TIME_W-1:0] t_mrd,
    input  logic [TIME_W-1:0] t_mod,
    input  logic [TIME_W-1:0] t_mprr,
    input  logic [TIME_W-1:0] t_gap,
    input  logic              expired,
    output iss_e              iss,
    output logic              restart,
    output logic [TIME_W-1:0] target,
    output logic              fin,
    output logic              busy
);
    st_e    st_q, st_d;
    times_t tq;
    logic   stop_q, stop_now;

    assign stop_now = stop_q | cap_ok;
    assign busy     = (st_q != ST_IDLE);
    assign restart  = (iss != ISS_NONE);

    always_comb begin
        unique case (st_q)
            ST_PRE_WAIT: target = tq.rp;
            ST_ON_WAIT:  target = tq.mode;
            ST_RD_WAIT:  target = stop_now ? tq.mprr : tq.gap;
            ST_OFF_WAIT: target = tq.mode;
            default:     target = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        iss  = ISS_NONE;
        fin  = 1'b0;
        unique case (st_q)
            ST_IDLE: if (start) begin
                iss  = ISS_PRE;
                st_d = ST_PRE_WAIT;
            end
            ST_PRE_WAIT: if (expired) begin
                iss  = ISS_MPR_ON;
                st_d = ST_ON_WAIT;
            end
            ST_ON_WAIT: if (expired) begin
                iss  = ISS_READ;
                st_d = ST_RD_WAIT;
            end
            ST_RD_WAIT: if (expired) begin
                if (stop_now) begin
                    iss  = ISS_MPR_OFF;
                    st_d = ST_OFF_WAIT;
                end else begin
                    iss = ISS_READ;
                end
            end
            ST_OFF_WAIT: if (expired) begin
                fin  = 1'b1;
                st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            stop_q <= 1'b0;
            tq     <= '0;
        end else begin
            st_q   <= st_d;
            stop_q <= (st_q == ST_RD_WAIT && st_d == ST_RD_WAIT) ? stop_now : 1'b0;
            if (st_q == ST_IDLE && start) begin
                tq.rp   <= wait_tgt(t_rp, TIME_W'(1));
                tq.mode <= wait_tgt(tmax(t_mrd, t_mod), TIME_W'(1));
                tq.mprr <= wait_tgt(t_mprr, TIME_W'(1));
                tq.gap  <= wait_tgt(t_gap, TIME_W'(GAP_FLOOR));
            end
        end
    end

    // R7: once cap_ok has been seen in the loop, no further read is issued.
    a_r7_no_read_after_stop: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RD_WAIT && stop_q) |-> (iss != ISS_READ));
    // R11: latched targets stay put for the whole run.
    a_r11_targets_stable: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE) |=> $stable(tq));
endmodule

// File: rtl/rdcal_seq.sv
module rdcal_seq
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cap_ok,
    input  logic [TIME_W-1:0] t_rp,
    input  logic [TIME_W-1:0] t_mrd,
    input  logic [TIME_W-1:0] t_mod,
    input  logic [TIME_W-1:0] t_mprr,
    input  logic [TIME_W-1:0] t_gap,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              busy_o,
    output logic              done_o
);
    iss_e              iss;
    logic              restart, expired, fin, busy;
    logic [TIME_W-1:0] target;
    bus_t              bus_d, bus_q;
    logic              done_q;

    cal_fsm u_fsm (
        .clk(clk), .rst(rst), .start(start), .cap_ok(cap_ok),
        .t_rp(t_rp), .t_mrd(t_mrd), .t_mod(t_mod), .t_mprr(t_mprr), .t_gap(t_gap),
        .expired(expired), .iss(iss), .restart(restart), .target(target),
        .fin(fin), .busy(busy)
    );

    cal_wait u_wait (
        .clk(clk), .rst(rst), .restart(restart), .target(target), .expired(expired)
    );

    cal_enc u_enc (
        .kind(iss), .bus(bus_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q  <= '{cmd: CMD_NOP, ba: '0, addr: '0};
            done_q <= 1'b0;
        end else begin
            bus_q  <= bus_d;
            done_q <= fin;
        end
    end

    assign cmd_o  = bus_q.cmd;
    assign ba_o   = bus_q.ba;
    assign addr_o = bus_q.addr;
    assign busy_o = busy;
    assign done_o = done_q;

    // Checker-side read spacing counter (cycles since last visible read).
    logic [TIME_W-1:0] rd_age;
    logic              rd_seen;
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_age  <= '0;
            rd_seen <= 1'b0;
        end else begin
            if (bus_q.cmd == CMD_READ) begin
                rd_age  <= TIME_W'(1);
                rd_seen <= 1'b1;
            end else begin
                if (rd_age != '1) rd_age <= rd_age + TIME_W'(1);
                if (!busy) rd_seen <= 1'b0;
            end
        end
    end

    a_r10_no_write: assert property (@(posedge clk) disable iff (rst)
        bus_q.cmd != CMD_WRITE);
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
    a_r2_pre_first: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start) |=> (bus_q.cmd == CMD_PREALL && busy_o));
    a_r6_read_spacing: assert property (@(posedge clk) disable iff (rst)
        (bus_q.cmd == CMD_READ && rd_seen) |-> (rd_age >= TIME_W'(GAP_FLOOR)));
    a_r3_mrs_bank: assert property (@(posedge clk) disable iff (rst)
        (bus_q.cmd == CMD_MRS) |-> (bus_q.ba == BA_W'(MR3_SEL)));
endmodule

// File: tb/test_rdcal_seq.sv
`timescale 1ns/1ps
module test_rdcal_seq;
    logic        clk = 1'b0, rst = 1'b1, start = 1'b0, cap_ok = 1'b0;
    logic [7:0]  t_rp = '0, t_mrd = '0, t_mod = '0, t_mprr = '0, t_gap = '0;
    logic [2:0]  cmd_o, ba_o;
    logic [13:0] addr_o;
    logic        busy_o, done_o;

    int cyc = 0, n_cmp = 0, n_bad = 0;
    int exp_cmd[int], exp_ba[int], exp_addr[int];
    string exp_tag[int];
    int busy_s = -1, busy_e = -1, done_at = -1, stop_at = -1;
    string nop_tag = "R10";

    rdcal_seq i_rdcal_seq (
        .clk(clk), .rst(rst), .start(start), .cap_ok(cap_ok),
        .t_rp(t_rp), .t_mrd(t_mrd), .t_mod(t_mod), .t_mprr(t_mprr), .t_gap(t_gap),
        .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o), .busy_o(busy_o), .done_o(done_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, int act, int expv, string what);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (edge %0d)", tag, what, act, expv, cyc);
        end
    endtask

    task automatic put(int e, int c, int b, int a, string tag);
        exp_cmd[e] = c; exp_ba[e] = b; exp_addr[e] = a; exp_tag[e] = tag;
    endtask

    // Per-cycle comparison against the integer schedule.
    always @(negedge clk) begin
        int ec, eb, ea;
        string tg;
        if (!rst) begin
            ec = 0; eb = 0; ea = 0; tg = nop_tag;
            if (exp_cmd.exists(cyc)) begin
                ec = exp_cmd[cyc]; eb = exp_ba[cyc]; ea = exp_addr[cyc]; tg = exp_tag[cyc];
            end else if (stop_at >= 0 && cyc >= stop_at && cyc < busy_e) begin
                tg = "R7";
            end
            chk(tg, int'(cmd_o), ec, "cmd");
            chk(tg, int'(ba_o), eb, "bank");
            chk(tg, int'(addr_o), ea, "addr");
            chk("R9", int'(busy_o), int'(cyc >= busy_s && cyc < busy_e), "busy");
            chk("R9", int'(done_o), int'(cyc == done_at), "done");
        end
    end

    task automatic run(int rp, int mrd, int mod, int mprr, int gap, int cap_ofs, bit stray);
        int s, tp, tm, g, m, e, r, l, c, x, d;
        bit first;
        @(negedge clk);
        t_rp = 8'(rp); t_mrd = 8'(mrd); t_mod = 8'(mod); t_mprr = 8'(mprr); t_gap = 8'(gap);
        start = 1'b1;
        s  = cyc + 1;
        tp = (rp < 1) ? 1 : rp;
        tm = (mrd > mod) ? mrd : mod;
        if (tm < 1) tm = 1;
        g  = (gap < 4) ? 4 : gap;
        m  = (mprr < 1) ? 1 : mprr;
        e  = s + tp;
        r  = e + tm;
        c  = r + cap_ofs;
        put(s, 1, 0, 'h400, "R2");
        put(e, 2, 3, 'h004, "R3");
        first = 1'b1;
        l = r;
        while (r < c) begin
            put(r, 3, 0, 'h1000, first ? "R4,R5" : "R5,R6");
            l = r; first = 1'b0; r += g;
        end
        x = (c > l + m) ? c : l + m;
        put(x, 2, 3, 0, "R8");
        d = x + tm;
        busy_s = s; busy_e = d; done_at = d; stop_at = c;
        nop_tag = stray ? "R11" : "R10";
        @(negedge clk);
        start = 1'b0;
        if (stray) begin
            // R11: stray start and new timing values while busy must change nothing.
            repeat (2) @(negedge clk);
            start = 1'b1; t_rp = 8'd200; t_mod = 8'd200; t_gap = 8'd100; t_mprr = 8'd90;
            @(negedge clk);
            start = 1'b0;
        end
        while (cyc < c - 1) @(negedge clk);
        cap_ok = 1'b1;
        while (cyc < d + 1) @(negedge clk);
        cap_ok = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", int'(cmd_o), 0, "cmd");
        chk("R1", int'(addr_o), 0, "addr");
        chk("R1", int'(busy_o), 0, "busy");
        chk("R1", int'(done_o), 0, "done");
        rst = 1'b0;
        repeat (4) @(negedge clk);
        run(5, 4, 12, 3, 6, 14, 1'b1);  // exit held back by t_mprr, stray start
        run(0, 0, 0, 0, 0, 9, 1'b0);    // all waits clamp to floors
        run(3, 7, 2, 20, 4, 1, 1'b0);   // single read, long t_mprr
        run(2, 1, 3, 2, 5, 10, 1'b0);   // R7: cap_ok lands on a due read
        run(1, 2, 2, 1, 2, 13, 1'b0);   // R6: gap below floor of 4
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule